// File: doc/BRIEF.md
# Commit Thread Selector

This block decides, once per commit slot, which hardware thread of a multithreaded out-of-order core may try to retire the instruction at the head of its reorder buffer. For every thread it receives an active flag, a three-bit thread state, a reorder-buffer-empty flag, a head-ready flag and the head instruction's sequence number. It answers in the same cycle with a thread id and a valid bit.

Two policies are selected by `mode_i`. In rotating mode the block keeps a priority order of thread ids in registers. It grants the first qualified thread in that order. When the commit logic pulses `accept_i`, the granted thread moves to the back of the order. In age mode the block grants the qualified thread whose head carries the smallest sequence number. This mode has no state, so the commit logic may call it several times within one cycle for a greedy policy. A build with a single thread reduces the block to an eligibility test of that thread.

Top module: `commit_thread_pick`

## Requirements
- R1: Thread state encoding: 0 running, 1 idle, 2 buffer squashing, 3 trap waiting, 4 fetch-trap waiting, and 5 to 7 unused. Only states 0, 1 and 4 make a thread eligible.
- R2: With more than one thread, a thread is qualified only when it is active, in an eligible state, has a non-empty reorder buffer and has a ready head. This applies in both modes.
- R3: In rotating mode (`mode_i`=0) the grant goes to the first qualified thread found while walking the priority order from the front.
- R4: In rotating mode, when `accept_i` is high with a valid grant at a clock edge, the granted thread moves to the back of the order and the others close up, keeping their relative order. Without `accept_i`, the order does not change.
- R5: After reset the priority order is ascending thread id, with thread 0 at the front.
- R6: In age mode (`mode_i`=1) the grant goes to the qualified thread with the smallest unsigned head sequence number. On equal numbers the lower thread id wins.
- R7: Accepting a grant in age mode leaves the rotating order unchanged.
- R8: When no thread is qualified, `pick_valid_o` is 0 and `pick_tid_o` is 0.
- R9: With a single thread (N=1), `pick_valid_o` is 1 exactly when that thread is active and in an eligible state, whatever its buffer flags are. `pick_tid_o` is then always 0.
- R10: The grant is combinational. It reflects the present inputs and the registered order in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 rotating order, 1 oldest head first |
| accept_i | input | 1 | Commit logic took the current grant |
| thr_active_i | input | N | Thread is active |
| thr_status_i | input | 3*N | Per-thread state, thread t in bits [3t+2:3t] |
| rob_empty_i | input | N | Thread's reorder buffer is empty |
| head_ready_i | input | N | Thread's head instruction is ready |
| head_seq_i | input | SEQ_W*N | Head sequence number, thread t in bits [SEQ_W*t +: SEQ_W] |
| pick_valid_o | output | 1 | A thread is granted |
| pick_tid_o | output | TID_W | Granted thread id |

## Verification
The only state is the rotating order. A corrupted order shows up as a wrong thread id on the very next rotating-mode grant in which two or more threads are qualified. A lost or wrong update after an accept shows up in the same way one cycle later. The bench therefore keeps its own copy of the order and compares every combinational grant against it across sweeps of qualification masks. Faults in the age comparison or in eligibility decoding appear at once at the outputs, because no register lies on those paths.

// File: rtl/cts_pkg.sv
package cts_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        TS_RUN        = 3'd0,
        TS_IDLE       = 3'd1,
        TS_ROB_SQ     = 3'd2,
        TS_TRAP_WAIT  = 3'd3,
        TS_FTRAP_WAIT = 3'd4
    } thr_state_e;

    function automatic logic state_ok(input logic [STATE_W-1:0] s);
        return (s == TS_RUN) || (s == TS_IDLE) || (s == TS_FTRAP_WAIT);
    endfunction

endpackage

// File: rtl/cts_qualify.sv
module cts_qualify #(
    parameter int N = 4
) (
    input  logic [N-1:0]                    act_i,
    input  logic [N*cts_pkg::STATE_W-1:0]   state_i,
    input  logic [N-1:0]                    empty_i,
    input  logic [N-1:0]                    ready_i,
    output logic [N-1:0]                    qual_o
);
    localparam int SW = cts_pkg::STATE_W;

    for (genvar t = 0; t < N; t++) begin : g_thr
        assign qual_o[t] = act_i[t] & cts_pkg::state_ok(state_i[t*SW +: SW])
                         & ~empty_i[t] & ready_i[t];
    end
endmodule

// File: rtl/cts_rr_order.sv
module cts_rr_order #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     qual_i,
    input  logic             upd_i,
    output logic             hit_o,
    output logic [TID_W-1:0] tid_o
);
    typedef struct packed {
        logic [N-1:0][TID_W-1:0] order;
    } rr_state_t;

    rr_state_t        st_d, st_q;
    logic [TID_W-1:0] pos;

    always_comb begin
        hit_o = 1'b0;
        tid_o = '0;
        pos   = '0;
        for (int i = 0; i < N; i++) begin
            if (!hit_o && qual_i[st_q.order[i]]) begin
                hit_o = 1'b1;
                tid_o = st_q.order[i];
                pos   = TID_W'(i);
            end
        end
        st_d = st_q;
        if (upd_i && hit_o) begin
            for (int i = 0; i < N - 1; i++) begin
                if (i >= int'(pos)) begin
                    st_d.order[i] = st_q.order[i+1];
                end
            end
            st_d.order[N-1] = tid_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                st_q.order[i] <= TID_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cts_age_pick.sv
module cts_age_pick #(
    parameter int N     = 4,
    parameter int SEQ_W = 8,
    parameter int TID_W = 2
) (
    input  logic [N-1:0]       qual_i,
    input  logic [N*SEQ_W-1:0] seq_i,
    output logic               hit_o,
    output logic [TID_W-1:0]   tid_o
);
    logic [SEQ_W-1:0] best;

    always_comb begin
        hit_o = 1'b0;
        tid_o = '0;
        best  = '0;
        for (int t = 0; t < N; t++) begin
            if (qual_i[t] && (!hit_o || (seq_i[t*SEQ_W +: SEQ_W] < best))) begin
                hit_o = 1'b1;
                best  = seq_i[t*SEQ_W +: SEQ_W];
                tid_o = TID_W'(t);
            end
        end
    end
endmodule

// File: rtl/commit_thread_pick.sv
module commit_thread_pick #(
    parameter  int N     = 4,
    parameter  int SEQ_W = 8,
    localparam int TID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_i,
    input  logic                          accept_i,
    input  logic [N-1:0]                  thr_active_i,
    input  logic [N*cts_pkg::STATE_W-1:0] thr_status_i,
    input  logic [N-1:0]                  rob_empty_i,
    input  logic [N-1:0]                  head_ready_i,
    input  logic [N*SEQ_W-1:0]            head_seq_i,
    output logic                          pick_valid_o,
    output logic [TID_W-1:0]              pick_tid_o
);
    if (N == 1) begin : g_single
        assign pick_valid_o = thr_active_i[0]
                            & cts_pkg::state_ok(thr_status_i[cts_pkg::STATE_W-1:0]);
        assign pick_tid_o   = '0;
    end else begin : g_multi
        logic [N-1:0]     qual;
        logic             rr_hit, age_hit;
        logic [TID_W-1:0] rr_tid, age_tid;

        cts_qualify #(.N(N)) u_qual (
            .act_i   (thr_active_i),
            .state_i (thr_status_i),
            .empty_i (rob_empty_i),
            .ready_i (head_ready_i),
            .qual_o  (qual)
        );

        cts_rr_order #(.N(N), .TID_W(TID_W)) u_rr (
            .clk    (clk),
            .rst_n  (rst_n),
            .qual_i (qual),
            .upd_i  (accept_i & ~mode_i),
            .hit_o  (rr_hit),
            .tid_o  (rr_tid)
        );

        cts_age_pick #(.N(N), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
            .qual_i (qual),
            .seq_i  (head_seq_i),
            .hit_o  (age_hit),
            .tid_o  (age_tid)
        );

        always_comb begin
            if (mode_i) begin
                pick_valid_o = age_hit;
                pick_tid_o   = age_tid;
            end else begin
                pick_valid_o = rr_hit;
                pick_tid_o   = rr_tid;
            end
        end
    end
endmodule

// File: rtl/cts_checker.sv
module cts_checker #(
    parameter int N     = 4,
    parameter int SEQ_W = 8,
    parameter int TID_W = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          mode_i,
    input logic                          accept_i,
    input logic [N-1:0]                  thr_active_i,
    input logic [N*cts_pkg::STATE_W-1:0] thr_status_i,
    input logic [N-1:0]                  rob_empty_i,
    input logic [N-1:0]                  head_ready_i,
    input logic [N*SEQ_W-1:0]            head_seq_i,
    input logic                          pick_valid_o,
    input logic [TID_W-1:0]              pick_tid_o
);
    if (N > 1) begin : g_chk
        logic [N-1:0]     q;
        logic             older;
        logic [SEQ_W-1:0] pseq;

        always_comb begin
            for (int t = 0; t < N; t++) begin
                q[t] = thr_active_i[t] && !rob_empty_i[t] && head_ready_i[t]
                    && (thr_status_i[t*3 +: 3] inside {3'd0, 3'd1, 3'd4});
            end
            pseq  = head_seq_i[int'(pick_tid_o)*SEQ_W +: SEQ_W];
            older = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (q[j] && ((head_seq_i[j*SEQ_W +: SEQ_W] < pseq) ||
                    ((head_seq_i[j*SEQ_W +: SEQ_W] == pseq) && (j < int'(pick_tid_o)))))
                    older = 1'b1;
            end
        end

        a_r2_grant_qualified: assert property (@(posedge clk) disable iff (!rst_n)
            pick_valid_o |-> q[pick_tid_o]);

        a_r8_none_invalid: assert property (@(posedge clk) disable iff (!rst_n)
            (q == '0) |-> (!pick_valid_o && pick_tid_o == '0));

        a_r3_grant_when_any: assert property (@(posedge clk) disable iff (!rst_n)
            (q != '0) |-> pick_valid_o);

        a_r6_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i && pick_valid_o) |-> !older);

        a_r4_granted_to_back: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_i && accept_i && pick_valid_o) |=>
            ((!mode_i && $countones(q) >= 2) -> (pick_tid_o != $past(pick_tid_o))));
    end
endmodule

bind commit_thread_pick cts_checker #(.N(N), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .accept_i     (accept_i),
    .thr_active_i (thr_active_i),
    .thr_status_i (thr_status_i),
    .rob_empty_i  (rob_empty_i),
    .head_ready_i (head_ready_i),
    .head_seq_i   (head_seq_i),
    .pick_valid_o (pick_valid_o),
    .pick_tid_o   (pick_tid_o)
);

// File: tb/sim_commit_thread_pick.sv
`timescale 1ns/1ps
module sim_commit_thread_pick;
    localparam int N = 4;
    localparam int SW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0, acc = 1'b0;
    logic [3:0]  act = '0, emp = '0, rdy = '0;
    logic [11:0] st = '0;
    logic [31:0] seq = '0;
    logic        v;
    logic [1:0]  tid;

    logic        s_act = 1'b0, s_emp = 1'b0, s_rdy = 1'b0;
    logic [2:0]  s_st = '0;
    logic        s_v;
    logic [0:0]  s_tid;

    int checks = 0, fails = 0;
    int m_ord [4];

    always #2 clk = ~clk;

    commit_thread_pick #(.N(N), .SEQ_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .accept_i(acc),
        .thr_active_i(act), .thr_status_i(st), .rob_empty_i(emp),
        .head_ready_i(rdy), .head_seq_i(seq),
        .pick_valid_o(v), .pick_tid_o(tid));

    commit_thread_pick #(.N(1), .SEQ_W(SW)) u1 (
        .clk(clk), .rst_n(rst_n), .mode_i(1'b0), .accept_i(1'b0),
        .thr_active_i(s_act), .thr_status_i(s_st), .rob_empty_i(s_emp),
        .head_ready_i(s_rdy), .head_seq_i(8'd0),
        .pick_valid_o(s_v), .pick_tid_o(s_tid));

    function automatic bit ok_st(int s);
        return s == 0 || s == 1 || s == 4;
    endfunction

    function automatic bit qf(int t);
        return act[t] && ok_st(int'(st[t*3 +: 3])) && !emp[t] && rdy[t];
    endfunction

    task automatic chk(string req, int av, int at, int ev, int et);
        checks++;
        if (av != ev || at != et) begin
            fails++;
            $display("FAIL %s: valid/tid got %0d/%0d expected %0d/%0d", req, av, at, ev, et);
        end
    endtask

    // expected grant, computed from R3/R6/R8
    task automatic expect_pick(output int ev, output int et);
        int best;
        ev = 0; et = 0; best = 0;
        if (!mode) begin
            for (int i = 0; i < 4; i++)
                if (ev == 0 && qf(m_ord[i])) begin ev = 1; et = m_ord[i]; end
        end else begin
            for (int t = 0; t < 4; t++)
                if (qf(t) && (ev == 0 || int'(seq[t*8 +: 8]) < best)) begin
                    ev = 1; et = t; best = int'(seq[t*8 +: 8]);
                end
        end
    endtask

    // check now, then let the edge happen and update the model (R4/R7)
    task automatic step(string req);
        int ev, et, p;
        #1;
        expect_pick(ev, et);
        chk(req, int'(v), int'(tid), ev, et);
        if (acc && ev == 1 && !mode) begin
            p = 0;
            for (int i = 0; i < 4; i++) if (m_ord[i] == et) p = i;
            for (int i = 0; i < 3; i++) if (i >= p) m_ord[i] = m_ord[i+1];
            m_ord[3] = et;
        end
        @(negedge clk);
    endtask

    task automatic all_ready();
        act = 4'hF; emp = 4'h0; rdy = 4'hF; st = '0;
    endtask

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_ord[i] = i;
        repeat (3) @(negedge clk);
        #1;
        chk("R8 reset idle", int'(v), int'(tid), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset order, R3/R4 rotation with all threads qualified, R10 same-cycle
        all_ready();
        step("R5 R10 order after reset");
        acc = 1'b1;
        for (int k = 0; k < 6; k++) step("R4 rotate all ready");
        acc = 1'b0;
        step("R4 no accept first");
        step("R4 no accept holds");

        // R1 status sweep, one candidate at a time
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 8; s++) begin
                act = 4'b0; act[t] = 1'b1; rdy = 4'hF; emp = 4'h0;
                st = '0; st[t*3 +: 3] = 3'(s);
                step("R1 state eligibility");
            end

        // R2/R3/R4 rotating sweep with masks applied via empty or not ready
        for (int it = 0; it < 128; it++) begin
            logic [3:0] m;
            m = 4'((it * 7 + 3) % 16);
            act = 4'hF; st = '0;
            st[(it % 4)*3 +: 3] = (it[2]) ? 3'd4 : 3'd1;
            rdy = it[1] ? 4'hF : m;
            emp = it[1] ? ~m : 4'h0;
            acc = it[0] ^ it[3];
            step("R3 R2 rotating grant");
        end
        acc = 1'b0;

        // R6 age sweep with frequent ties; R7 accept in age mode
        mode = 1'b1;
        for (int it = 0; it < 256; it++) begin
            all_ready();
            act = 4'(it);
            for (int t = 0; t < 4; t++) seq[t*8 +: 8] = 8'(((it >> 4) * (t + 3) + t * 5) % 5 * 50);
            acc = 1'b1;
            step("R6 oldest head");
        end
        mode = 1'b0; acc = 1'b0;
        all_ready();
        step("R7 order kept through age accepts");
        rdy = 4'b0;
        step("R8 none qualified");

        // R9 single-thread build
        for (int c = 0; c < 64; c++) begin
            s_act = c[0]; s_emp = c[1]; s_rdy = c[2]; s_st = 3'(c >> 3);
            #1;
            chk("R9 single thread", int'(s_v), int'(s_tid),
                (s_act && ok_st(int'(s_st))) ? 1 : 0, 0);
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule